// File: doc/BRIEF.md
# Dual-Bridge Fault Supervisor

This block guards two motor-drive bridges, A and B. It watches the over-threshold comparator flag of every FET on each bridge, a gate-drive overcurrent flag for each bridge, and one die over-temperature flag. From these it works out when each bridge may be driven, keeps a small status register, and drives a single active-low fault line.

An overcurrent flag counts as a real event only when it stays high on an enabled bridge for longer than a selectable deglitch time. Overcurrent and gate-drive faults are sticky. They shut down only the bridge they belong to, and software clears them by writing 0 to the status bit. Over-temperature works differently: it stops both bridges and the bridges start again by themselves once the die cools. The fault line is released one cycle after the bridges resume.

The per-FET deglitch filters are small state machines with three states:
- `DG_IDLE` is the rest state. It moves to `DG_COUNT` when the gated flag is high.
- `DG_COUNT` counts cycles. It moves to `DG_TRIP` once the count reaches the selected limit.
- `DG_TRIP` holds while the flag stays high.
- Any state returns to `DG_IDLE` as soon as the flag drops.

The thermal tracker also has three states:
- `TH_OK` moves to `TH_HOT` when over-temperature is sampled high.
- `TH_HOT` moves to `TH_RESUME` when over-temperature is sampled low.
- `TH_RESUME` lasts one cycle. It goes to `TH_OK`, or back to `TH_HOT` if the die is hot again.

Top module: `bridge_fault_supervisor`

## Requirements
- R1: Selecting a deglitch code gives a limit N, with `dglt_sel` 0→4, 1→8, 2→16 and 3→32 cycles by default. An overcurrent flag of an enabled bridge becomes an event only after it is sampled high on N+1 consecutive clock edges. Shorter runs are ignored, and a low sample restarts the count.
- R2: An overcurrent event sets that bridge's overcurrent bit on the next edge, then deasserts only that bridge's enable and pulls `fault_n` low. The bit positions are `status[0]` for A and `status[1]` for B.
- R3: An overcurrent bit and the shutdown it causes stay set until a write with `wr_en`=1 and a 0 in that bit position, or until reset. Writing 1 to the bit has no effect.
- R4: A gate-drive fault flag sampled high sets that bridge's gate-fault bit, disables that bridge and pulls `fault_n` low. The bit positions are `status[2]` for A and `status[3]` for B.
- R5: A gate-fault bit clears only on a write of 0 to that bit, or on reset. If the flag is still high on the clearing edge, the bit stays set.
- R6: Over-temperature sampled high sets `status[4]` after that edge, disables both bridges and pulls `fault_n` low.
- R7: When over-temperature is sampled low, `status[4]` clears and the bridges resume after that edge. `fault_n` is released one cycle later, provided no sticky fault is set. Writes to `status[4]` are ignored.
- R8: `fault_n` is low exactly when some status bit is set or the thermal tracker is in its resume cycle.
- R9: A bridge enable is high only when its request input is high, neither of its sticky bits is set, and `status[4]` is clear.
- R10: The overcurrent flags of a bridge that is not enabled are ignored. After a clear, the bit sets again only after a fresh deglitch run.
- R11: A synchronous reset clears all status bits, deglitch filters and shutdowns, leaving `fault_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| oc_flag_a | input | NUM_FET | Over-threshold flags, bridge A FETs |
| oc_flag_b | input | NUM_FET | Over-threshold flags, bridge B FETs |
| gate_flt_a | input | 1 | Gate-drive overcurrent flag, bridge A |
| gate_flt_b | input | 1 | Gate-drive overcurrent flag, bridge B |
| over_temp | input | 1 | Die over-temperature flag |
| dglt_sel | input | 2 | Deglitch time code |
| en_req_a | input | 1 | External enable request, bridge A |
| en_req_b | input | 1 | External enable request, bridge B |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 5 | Status write data; 0 clears a sticky bit |
| status | output | 5 | {thermal, gf_b, gf_a, oc_b, oc_a} |
| bridge_en_a | output | 1 | Bridge A may be driven |
| bridge_en_b | output | 1 | Bridge B may be driven |
| fault_n | output | 1 | Active-low fault indication |

## Verification
On every cycle, the assertions check the following:
- a deglitch filter only trips after a counting run on a high flag;
- sticky bits hold until a clear arrives;
- a gate-fault flag always latches;
- over-temperature always sets the thermal bit and removes both enables;
- the resume state only follows the hot state;
- `fault_n` is low whenever a status bit is set.

Some behaviours only the bench scenarios can show, because they depend on stimulus history:
- the exact pulse length that separates an ignored glitch from an event at each deglitch code;
- that a write of 1 or a write to the thermal bit changes nothing;
- that a flag on a disabled bridge leaves no trace;
- the one-cycle gap between the bridges resuming and `fault_n` being released.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

    typedef enum logic [1:0] {
        DG_IDLE  = 2'd0,
        DG_COUNT = 2'd1,
        DG_TRIP  = 2'd2
    } dg_state_t;

    typedef enum logic [1:0] {
        TH_OK     = 2'd0,
        TH_HOT    = 2'd1,
        TH_RESUME = 2'd2
    } th_state_t;

    localparam int ST_W       = 5;
    localparam int ST_OC_A    = 0;
    localparam int ST_OC_B    = 1;
    localparam int ST_GF_A    = 2;
    localparam int ST_GF_B    = 3;
    localparam int ST_THERMAL = 4;

endpackage

// File: rtl/bfs_deglitch.sv
module bfs_deglitch
    import bfs_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flag_in,
    input  logic [CNT_W-1:0] limit,
    output logic             qualified
);

    dg_state_t        state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= DG_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (!flag_in) begin
            state_nx = DG_IDLE;
            cnt_nx   = '0;
        end else begin
            unique case (state)
                DG_IDLE: begin
                    state_nx = DG_COUNT;
                    cnt_nx   = {{(CNT_W-1){1'b0}}, 1'b1};
                end
                DG_COUNT: begin
                    if (cnt >= limit) state_nx = DG_TRIP;
                    else              cnt_nx   = cnt + 1'b1;
                end
                DG_TRIP: state_nx = DG_TRIP;
                default: begin
                    state_nx = DG_IDLE;
                    cnt_nx   = '0;
                end
            endcase
        end
    end

    always_comb begin
        qualified = (state == DG_TRIP);
    end

    AST_TRIP_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        (state == DG_TRIP) |-> ($past(flag_in) && $past(state) != DG_IDLE)); // R1

endmodule

// File: rtl/bfs_thermal.sv
module bfs_thermal
    import bfs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic over_temp,
    output logic hot,
    output logic hold_fault
);

    th_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= TH_OK;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TH_OK:     if (over_temp) state_nx = TH_HOT;
            TH_HOT:    if (!over_temp) state_nx = TH_RESUME;
            TH_RESUME: state_nx = over_temp ? TH_HOT : TH_OK;
            default:   state_nx = TH_OK;
        endcase
    end

    always_comb begin
        hot        = (state == TH_HOT);
        hold_fault = (state != TH_OK);
    end

    AST_HOT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        over_temp |=> hot); // R6
    AST_RESUME_AFTER_HOT: assert property (@(posedge clk) disable iff (rst)
        (state == TH_RESUME) |-> ($past(state) == TH_HOT)); // R7

endmodule

// File: rtl/bfs_bridge.sv
module bfs_bridge #(
    parameter int NUM_FET = 4,
    parameter int CNT_W   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_FET-1:0] oc_flags,
    input  logic               gate_flt,
    input  logic [CNT_W-1:0]   limit,
    input  logic               en_req,
    input  logic               therm_block,
    input  logic               clr_oc,
    input  logic               clr_gf,
    output logic               oc_bit,
    output logic               gf_bit,
    output logic               bridge_en
);

    logic [NUM_FET-1:0] gated;
    logic [NUM_FET-1:0] trip;
    logic               any_trip;
    logic               oc_q, gf_q;

    always_comb begin
        bridge_en = en_req && !oc_q && !gf_q && !therm_block;
        gated     = oc_flags & {NUM_FET{bridge_en}};
        any_trip  = |trip;
    end

    for (genvar g = 0; g < NUM_FET; g++) begin : g_fet
        bfs_deglitch #(.CNT_W(CNT_W)) i_dg (
            .clk       (clk),
            .rst       (rst),
            .flag_in   (gated[g]),
            .limit     (limit),
            .qualified (trip[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oc_q <= 1'b0;
            gf_q <= 1'b0;
        end else begin
            oc_q <= any_trip || (oc_q && !clr_oc);
            gf_q <= gate_flt || (gf_q && !clr_gf);
        end
    end

    always_comb begin
        oc_bit = oc_q;
        gf_bit = gf_q;
    end

    AST_OC_NEEDS_TRIP: assert property (@(posedge clk) disable iff (rst)
        $rose(oc_q) |-> $past(any_trip)); // R2
    AST_OC_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(oc_q) && !$past(clr_oc)) |-> oc_q); // R3
    AST_GF_LATCH: assert property (@(posedge clk) disable iff (rst)
        gate_flt |=> gf_q); // R4
    AST_GF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(gf_q) && !$past(clr_gf)) |-> gf_q); // R5

endmodule

// File: rtl/bridge_fault_supervisor.sv
module bridge_fault_supervisor
    import bfs_pkg::*;
#(
    parameter int NUM_FET  = 4,
    parameter int DG_CYC_0 = 4,
    parameter int DG_CYC_1 = 8,
    parameter int DG_CYC_2 = 16,
    parameter int DG_CYC_3 = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_FET-1:0] oc_flag_a,
    input  logic [NUM_FET-1:0] oc_flag_b,
    input  logic               gate_flt_a,
    input  logic               gate_flt_b,
    input  logic               over_temp,
    input  logic [1:0]         dglt_sel,
    input  logic               en_req_a,
    input  logic               en_req_b,
    input  logic               wr_en,
    input  logic [ST_W-1:0]    wr_data,
    output logic [ST_W-1:0]    status,
    output logic               bridge_en_a,
    output logic               bridge_en_b,
    output logic               fault_n
);

    localparam int MAX_01 = (DG_CYC_0 > DG_CYC_1) ? DG_CYC_0 : DG_CYC_1;
    localparam int MAX_23 = (DG_CYC_2 > DG_CYC_3) ? DG_CYC_2 : DG_CYC_3;
    localparam int MAX_DG = (MAX_01 > MAX_23) ? MAX_01 : MAX_23;
    localparam int CNT_W  = $clog2(MAX_DG + 1);
    localparam int NUM_BR = 2;

    logic [CNT_W-1:0]   dg_limit;
    logic               therm_hot, therm_hold;
    logic [NUM_FET-1:0] flags   [NUM_BR];
    logic [NUM_BR-1:0]  gflt, req, clr_oc, clr_gf, oc_bits, gf_bits, br_en;

    always_comb begin
        unique case (dglt_sel)
            2'd0: dg_limit = CNT_W'(DG_CYC_0);
            2'd1: dg_limit = CNT_W'(DG_CYC_1);
            2'd2: dg_limit = CNT_W'(DG_CYC_2);
            2'd3: dg_limit = CNT_W'(DG_CYC_3);
            default: dg_limit = CNT_W'(DG_CYC_0);
        endcase
    end

    always_comb begin
        flags[0] = oc_flag_a;
        flags[1] = oc_flag_b;
        gflt     = {gate_flt_b, gate_flt_a};
        req      = {en_req_b, en_req_a};
        clr_oc   = {wr_en && !wr_data[ST_OC_B], wr_en && !wr_data[ST_OC_A]};
        clr_gf   = {wr_en && !wr_data[ST_GF_B], wr_en && !wr_data[ST_GF_A]};
    end

    bfs_thermal i_thermal (
        .clk        (clk),
        .rst        (rst),
        .over_temp  (over_temp),
        .hot        (therm_hot),
        .hold_fault (therm_hold)
    );

    for (genvar b = 0; b < NUM_BR; b++) begin : g_br
        bfs_bridge #(.NUM_FET(NUM_FET), .CNT_W(CNT_W)) i_bridge (
            .clk         (clk),
            .rst         (rst),
            .oc_flags    (flags[b]),
            .gate_flt    (gflt[b]),
            .limit       (dg_limit),
            .en_req      (req[b]),
            .therm_block (therm_hot),
            .clr_oc      (clr_oc[b]),
            .clr_gf      (clr_gf[b]),
            .oc_bit      (oc_bits[b]),
            .gf_bit      (gf_bits[b]),
            .bridge_en   (br_en[b])
        );
    end

    always_comb begin
        status[ST_OC_A]    = oc_bits[0];
        status[ST_OC_B]    = oc_bits[1];
        status[ST_GF_A]    = gf_bits[0];
        status[ST_GF_B]    = gf_bits[1];
        status[ST_THERMAL] = therm_hot;
        bridge_en_a        = br_en[0];
        bridge_en_b        = br_en[1];
        fault_n            = !((|oc_bits) || (|gf_bits) || therm_hold);
    end

    AST_THERM_GATES: assert property (@(posedge clk) disable iff (rst)
        status[ST_THERMAL] |-> (!bridge_en_a && !bridge_en_b)); // R6
    AST_FAULT_LOW: assert property (@(posedge clk) disable iff (rst)
        (|status) |-> !fault_n); // R8

endmodule

// File: tb/test_bridge_fault_supervisor.sv
`timescale 1ns/1ps
module test_bridge_fault_supervisor;

    localparam int NF = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NF-1:0] oc_a = '0, oc_b = '0;
    logic          gf_a = 0, gf_b = 0, ot = 0, req_a = 1, req_b = 1, wr_en = 0;
    logic [1:0]    sel = 2'd0;
    logic [4:0]    wr_data = '0;
    logic [4:0]    status;
    logic          en_a, en_b, fault_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    bridge_fault_supervisor #(.NUM_FET(NF)) i_bridge_fault_supervisor (
        .clk(clk), .rst(rst), .oc_flag_a(oc_a), .oc_flag_b(oc_b),
        .gate_flt_a(gf_a), .gate_flt_b(gf_b), .over_temp(ot), .dglt_sel(sel),
        .en_req_a(req_a), .en_req_b(req_b), .wr_en(wr_en), .wr_data(wr_data),
        .status(status), .bridge_en_a(en_a), .bridge_en_b(en_b), .fault_n(fault_n));

    // reference model built from the requirements
    int mst [2][NF];
    int mcnt[2][NF];
    bit moc [2];
    bit mgf [2];
    int mth;  // 0 ok, 1 hot, 2 resume

    function automatic int lim_of(input logic [1:0] s);
        return (s == 2'd0) ? 4 : (s == 2'd1) ? 8 : (s == 2'd2) ? 16 : 32;
    endfunction

    function automatic bit exp_en(input int b);
        return (b == 0 ? req_a : req_b) && !moc[b] && !mgf[b] && (mth != 1);
    endfunction

    function automatic logic [4:0] exp_status();
        return {mth == 1, mgf[1], mgf[0], moc[1], moc[0]};
    endfunction

    function automatic bit exp_fault_n();
        return !(moc[0] || moc[1] || mgf[0] || mgf[1] || mth != 0);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < 2; b++) begin
                moc[b] = 0;
                mgf[b] = 0;
                for (int f = 0; f < NF; f++) begin
                    mst[b][f]  = 0;
                    mcnt[b][f] = 0;
                end
            end
            mth = 0;
        end else begin
            bit en[2];
            bit trip[2];
            for (int b = 0; b < 2; b++) begin
                en[b]   = exp_en(b);
                trip[b] = 0;
                for (int f = 0; f < NF; f++) if (mst[b][f] == 2) trip[b] = 1;
            end
            for (int b = 0; b < 2; b++) begin
                for (int f = 0; f < NF; f++) begin
                    bit fl;
                    fl = (b == 0 ? oc_a[f] : oc_b[f]) && en[b];
                    if (!fl) begin
                        mst[b][f]  = 0;
                        mcnt[b][f] = 0;
                    end else if (mst[b][f] == 0) begin
                        mst[b][f]  = 1;
                        mcnt[b][f] = 1;
                    end else if (mst[b][f] == 1) begin
                        if (mcnt[b][f] >= lim_of(sel)) mst[b][f] = 2;
                        else                           mcnt[b][f]++;
                    end
                end
                moc[b] = trip[b] || (moc[b] && !(wr_en && !wr_data[b]));
                mgf[b] = (b == 0 ? gf_a : gf_b) || (mgf[b] && !(wr_en && !wr_data[2+b]));
            end
            if (mth == 0)      mth = ot ? 1 : 0;
            else if (mth == 1) mth = ot ? 1 : 2;
            else               mth = ot ? 1 : 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_model();
        logic [4:0] es;
        es = exp_status();
        chk(status[1:0] == es[1:0], "R2 oc bits", status[1:0], es[1:0]);
        chk(status[3:2] == es[3:2], "R4 gf bits", status[3:2], es[3:2]);
        chk(status[4] == es[4], "R6 thermal bit", status[4], es[4]);
        chk(en_a == exp_en(0), "R9 enable A", en_a, exp_en(0));
        chk(en_b == exp_en(1), "R9 enable B", en_b, exp_en(1));
        chk(fault_n == exp_fault_n(), "R8 fault_n", fault_n, exp_fault_n());
    endtask

    // one cycle: sample at the falling edge, then drive is allowed
    task automatic cyc();
        @(negedge clk);
        compare_model();
    endtask

    task automatic idle_inputs();
        oc_a = '0; oc_b = '0; gf_a = 0; gf_b = 0; ot = 0;
        req_a = 1; req_b = 1; wr_en = 0; wr_data = '0;
    endtask

    task automatic write_status(input logic [4:0] d);
        wr_en = 1; wr_data = d;
        cyc();
        wr_en = 0; wr_data = '0;
    endtask

    task automatic do_reset();
        rst = 1;
        idle_inputs();
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic pulse_oc_a(input int edges);
        oc_a[1] = 1;
        repeat (edges) cyc();
        oc_a[1] = 0;
        repeat (3) cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        @(negedge clk);

        // R11 reset state
        chk(status == 5'd0 && fault_n && en_a && en_b, "R11 reset state",
            {status, fault_n, en_a, en_b}, {5'd0, 3'b111});

        // R1 deglitch boundary at every code
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            pulse_oc_a(lim_of(2'(s)));
            chk(status[0] == 0, "R1 pulse of N edges ignored", status[0], 0);
            pulse_oc_a(lim_of(2'(s)) + 1);
            chk(status[0] == 1 && !en_a && en_b && !fault_n, "R1 R2 N+1 edges trips A only",
                {status[0], en_a, en_b, fault_n}, 4'b1010);
            // R3: writing ones changes nothing
            write_status(5'b11111);
            cyc();
            chk(status[0] == 1 && !en_a, "R3 write 1 no effect", status[0], 1);
            write_status(5'b11110);
            cyc();
            chk(status[0] == 0 && en_a && fault_n, "R3 write 0 clears oc", status[0], 0);
        end

        // R1 a drop restarts the count
        sel = 2'd0;
        oc_a[0] = 1; repeat (3) cyc(); oc_a[0] = 0; cyc();
        oc_a[0] = 1; repeat (3) cyc(); oc_a[0] = 0; repeat (3) cyc();
        chk(status[0] == 0, "R1 broken run ignored", status[0], 0);

        // R10 flags ignored on a disabled bridge
        req_b = 0;
        oc_b = '1; repeat (40) cyc();
        chk(status[1] == 0 && !en_b, "R10 disabled bridge flags ignored", status[1], 0);
        oc_b = '0; req_b = 1; repeat (2) cyc();

        // R10 re-latch needs a fresh run after clear
        oc_b[2] = 1; repeat (8) cyc();
        chk(status[1] == 1, "R2 bridge B trips", status[1], 1);
        write_status(5'b11101);
        chk(status[1] == 0 && en_b, "R10 cleared while flag high", status[1], 0);
        repeat (3) cyc();
        chk(status[1] == 0, "R10 no immediate re-latch", status[1], 0);
        repeat (4) cyc();
        chk(status[1] == 1, "R10 re-latch after fresh run", status[1], 1);
        oc_b = '0; write_status(5'b11101);

        // R4 R5 gate fault
        gf_a = 1; cyc();
        chk(status[2] == 1 && !en_a && !fault_n, "R4 gate fault latches", status[2], 1);
        write_status(5'b11011);
        chk(status[2] == 1, "R5 clear while flag high keeps bit", status[2], 1);
        gf_a = 0; cyc();
        chk(status[2] == 1, "R5 bit sticky after flag drop", status[2], 1);
        write_status(5'b11011);
        chk(status[2] == 0 && en_a && fault_n, "R5 write 0 clears gf", status[2], 0);

        // R6 R7 thermal
        ot = 1; cyc();
        chk(status[4] == 1 && !en_a && !en_b && !fault_n, "R6 thermal shuts both",
            {status[4], en_a, en_b, fault_n}, 4'b1000);
        write_status(5'b01111);
        chk(status[4] == 1, "R7 write to thermal bit ignored", status[4], 1);
        ot = 0; cyc();
        chk(status[4] == 0 && en_a && en_b && !fault_n, "R7 resume before release",
            {status[4], en_a, en_b, fault_n}, 4'b0110);
        cyc();
        chk(fault_n == 1, "R7 fault released one cycle later", fault_n, 1);

        // R11 reset in the middle of faults
        gf_b = 1; ot = 1; oc_a = '1; repeat (8) cyc();
        do_reset();
        @(negedge clk);
        chk(status == 5'd0 && fault_n && en_a && en_b, "R11 reset clears all",
            {status, fault_n}, 6'b000001);

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            for (int f = 0; f < NF; f++) begin
                if ($urandom_range(0, 11) == 0) oc_a[f] = ~oc_a[f];
                if ($urandom_range(0, 11) == 0) oc_b[f] = ~oc_b[f];
            end
            gf_a  = ($urandom_range(0, 199) == 0);
            gf_b  = ($urandom_range(0, 199) == 0);
            if ($urandom_range(0, 149) == 0) ot = ~ot;
            if ($urandom_range(0, 99) == 0) req_a = ~req_a;
            if ($urandom_range(0, 99) == 0) req_b = ~req_b;
            if ($urandom_range(0, 299) == 0) sel = 2'($urandom_range(0, 3));
            wr_en   = ($urandom_range(0, 39) == 0);
            wr_data = 5'($urandom_range(0, 31));
            cyc();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule